// File: doc/BRIEF.md
# Codec Mode and Reset Controller

This block sits at the control edge of a four-channel voice codec. It watches two mode pins and works out whether the device is being run by a host processor or set up by strap pins. From those pins, and from a self-clearing bit in the configuration word, it produces the one internal reset for the whole device. It also holds the configuration that the rest of the codec reads: the companding law, the 16-bit linear option, a transmit gain selection, and one power-down flag per channel.

The two mode pins are first passed through a synchronizer. When both synchronized levels are low the device is held in reset. When exactly one of them is high, that pin picks the mode: the first mode pin low selects processor mode, and the second mode pin low selects strap mode. In processor mode the host writes the configuration word directly. In strap mode the host port is ignored. The strap levels are captured on the first clock after a pin reset ends, and are captured again on every frame sync pulse.

The per-channel output enables go low whenever the device is in reset or that channel is powered down. The serial data slot of that channel then floats.

Top module: `codec_mode_ctrl`

## Requirements
- R1: While both synchronized mode pins are low, `dev_rst` is 1. On the clock edge after any cycle with `dev_rst` high, the configuration (law, linear, gain select, power-down flags) is cleared to zero.
- R2: `proc_mode` is 1 when the synchronized `mode_m0` is low and `mode_m1` is high, and 0 when `mode_m1` is low and `mode_m0` is high. In any other pin state it keeps its previous value, so it is unchanged across a reset pulse.
- R3: Each mode pin passes through two flip-flops. A pin change first shows on `dev_rst` and `proc_mode` after the second rising clock edge, with no further delay.
- R4: In processor mode outside reset, a write with `cfg_wr_data[7]` = 1 raises `dev_rst` for exactly one cycle, starting the cycle after the write. The rest of that write's word is discarded, and the configuration is cleared.
- R5: In processor mode outside reset, a write with bit 7 = 0 stores the word in the cycle after the write. The bit positions are: bit 6 linear coding, bit 5 A-law (1) or mu-law (0), bit 4 gain select, and bits 3:0 power down for channels 3..0. Writes made in strap mode or during reset have no effect.
- R6: In strap mode, on the first clock edge after a pin reset ends, the configuration is loaded from the strap pins. The power-down flags take `strap_pd`, the law takes `strap_alaw`, the gain select takes `strap_gain`, and linear is forced to 0.
- R7: In strap mode outside reset, a clock edge with `fsync` high reloads the configuration from the strap pins. Without `fsync` the configuration holds. `fsync` has no effect in processor mode.
- R8: `chan_dx_en[i]` is 1 only when `dev_rst` is 0 and `chan_pd[i]` is 0.
- R9: `tx_gain_code` is 8'hFF when the gain select is 1 and 8'h8F when it is 0.
- R10: While `sys_rst_n` is low, `dev_rst` = 1, `proc_mode` = 1, the configuration is zero and all `chan_dx_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| sys_rst_n | input | 1 | Asynchronous power-on reset for the flops, active low |
| mode_m0 | input | 1 | First mode pin (low selects processor mode) |
| mode_m1 | input | 1 | Second mode pin (low selects strap mode) |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration word to write |
| fsync | input | 1 | Frame sync strobe, one clock wide |
| strap_pd | input | 4 | Strap power-down level per channel, high = down |
| strap_alaw | input | 1 | Strap law select, high = A-law |
| strap_gain | input | 1 | Strap gain select, high = full gain |
| dev_rst | output | 1 | Device-wide reset, active high |
| proc_mode | output | 1 | 1 = processor mode, 0 = strap mode |
| cfg_alaw | output | 1 | A-law selected |
| cfg_linear | output | 1 | 16-bit linear coding selected |
| tx_gain_code | output | 8 | Transmit gain code derived from the gain select |
| chan_pd | output | 4 | Per-channel power-down flags |
| chan_dx_en | output | 4 | Per-channel PCM output enable |

## Verification
The assertions check, on every cycle, that the reset bit clears itself after one cycle and that the mode flag changes only when exactly one pin is high. They also check that the configuration is zero after any reset cycle, and that the configuration holds when no write, release or frame sync allows it to change. Other behaviours depend on sequences of pin events, so only the bench scenarios can show them. These are the two-edge synchronizer latency, the strap capture on reset release as opposed to a frame sync, writes being ignored in strap mode and during reset, and the full set of gain and enable outputs. A cycle model in the bench covers these across random traffic.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;
  localparam int NUM_CH   = 4;
  localparam int WORD_W   = 8;
  localparam int RES_BIT  = 7;
  localparam int LIN_BIT  = 6;
  localparam int LAW_BIT  = 5;
  localparam int GAIN_BIT = 4;
  localparam int SYNC_STAGES = 2;
  localparam logic [7:0] GAIN_FULL  = 8'hFF;
  localparam logic [7:0] GAIN_REDUC = 8'h8F;

  typedef struct packed {
    logic              linear;
    logic              alaw;
    logic              gain_full;
    logic [NUM_CH-1:0] pd;
  } cfg_t;

  // both mode pins low: device held in reset
  function automatic logic pin_reset(input logic m0, input logic m1);
    return ~(m0 | m1);
  endfunction

  // exactly one pin high selects the mode; otherwise keep the old one
  function automatic logic decode_mode(input logic m0, input logic m1,
                                       input logic prev);
    if (m0 ^ m1) return m1;
    return prev;
  endfunction

  function automatic cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.linear    = w[LIN_BIT];
    c.alaw      = w[LAW_BIT];
    c.gain_full = w[GAIN_BIT];
    c.pd        = w[NUM_CH-1:0];
    return c;
  endfunction

  function automatic cfg_t cfg_from_strap(input logic [NUM_CH-1:0] pd,
                                          input logic alaw, input logic gain);
    cfg_t c;
    c.linear    = 1'b0;
    c.alaw      = alaw;
    c.gain_full = gain;
    c.pd        = pd;
    return c;
  endfunction

  function automatic logic [7:0] gain_code(input logic full);
    return full ? GAIN_FULL : GAIN_REDUC;
  endfunction
endpackage

// File: rtl/mode_pin_sync.sv
module mode_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) chain_q <= '0;
      else            chain_q <= {chain_q[STAGES-2:0], pin_in[g]};
    end
    assign pin_sync[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl
  import codec_mode_pkg::*;
(
  input  logic clk,
  input  logic sys_rst_n,
  input  logic m0_s,
  input  logic m1_s,
  input  logic res_req,
  output logic dev_rst,
  output logic proc_mode,
  output logic rst_release
);
  logic mode_q;
  logic pin_rst_d;
  logic res_q;
  logic pin_rst;
  logic res_fire;

  assign pin_rst     = pin_reset(m0_s, m1_s);
  assign proc_mode   = decode_mode(m0_s, m1_s, mode_q);
  assign dev_rst     = pin_rst | res_q;
  assign rst_release = pin_rst_d & ~pin_rst;
  assign res_fire    = res_req & proc_mode & ~dev_rst;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      mode_q    <= 1'b1;
      pin_rst_d <= 1'b1;
      res_q     <= 1'b0;
    end else begin
      mode_q    <= proc_mode;
      pin_rst_d <= pin_rst;
      res_q     <= res_fire;
    end
  end

  // R4: the register reset bit lasts a single cycle
  assert_res_self_clear_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    res_q |=> !res_q);

  // R2: the mode flag only moves when exactly one pin is high
  assert_mode_change_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !$stable(proc_mode) |-> (m0_s ^ m1_s));
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import codec_mode_pkg::*;
(
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              dev_rst,
  input  logic              proc_mode,
  input  logic              rst_release,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              fsync,
  input  logic [NUM_CH-1:0] strap_pd,
  input  logic              strap_alaw,
  input  logic              strap_gain,
  output cfg_t              cfg
);
  cfg_t cfg_q;
  logic wr_take;
  logic strap_take;

  assign wr_take    = proc_mode & ~dev_rst & wr_en & ~wr_word[RES_BIT];
  assign strap_take = ~proc_mode & ~dev_rst & (rst_release | fsync);

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)      cfg_q <= '0;
    else if (dev_rst)    cfg_q <= '0;
    else if (wr_take)    cfg_q <= cfg_from_word(wr_word);
    else if (strap_take) cfg_q <= cfg_from_strap(strap_pd, strap_alaw, strap_gain);
  end

  assign cfg = cfg_q;

  // R1: any reset cycle leaves a cleared configuration behind
  assert_cleared_after_reset_R1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    dev_rst |=> (cfg_q == '0));

  // R7: strap mode holds the configuration between frame syncs
  assert_strap_hold_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!proc_mode && !dev_rst && !fsync && !rst_release) |=> $stable(cfg_q));

  // R5: processor mode holds the configuration without a write
  assert_proc_hold_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (proc_mode && !dev_rst && !wr_en) |=> $stable(cfg_q));
endmodule

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl
  import codec_mode_pkg::*;
(
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              mode_m0,
  input  logic              mode_m1,
  input  logic              cfg_wr_en,
  input  logic [WORD_W-1:0] cfg_wr_data,
  input  logic              fsync,
  input  logic [NUM_CH-1:0] strap_pd,
  input  logic              strap_alaw,
  input  logic              strap_gain,
  output logic              dev_rst,
  output logic              proc_mode,
  output logic              cfg_alaw,
  output logic              cfg_linear,
  output logic [7:0]        tx_gain_code,
  output logic [NUM_CH-1:0] chan_pd,
  output logic [NUM_CH-1:0] chan_dx_en
);
  logic [1:0] pins_s;
  logic       rst_release;
  cfg_t       cfg;

  mode_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .pin_in    ({mode_m1, mode_m0}),
    .pin_sync  (pins_s)
  );

  reset_ctrl u_rst (
    .clk         (clk),
    .sys_rst_n   (sys_rst_n),
    .m0_s        (pins_s[0]),
    .m1_s        (pins_s[1]),
    .res_req     (cfg_wr_en & cfg_wr_data[RES_BIT]),
    .dev_rst     (dev_rst),
    .proc_mode   (proc_mode),
    .rst_release (rst_release)
  );

  cfg_store u_cfg (
    .clk         (clk),
    .sys_rst_n   (sys_rst_n),
    .dev_rst     (dev_rst),
    .proc_mode   (proc_mode),
    .rst_release (rst_release),
    .wr_en       (cfg_wr_en),
    .wr_word     (cfg_wr_data),
    .fsync       (fsync),
    .strap_pd    (strap_pd),
    .strap_alaw  (strap_alaw),
    .strap_gain  (strap_gain),
    .cfg         (cfg)
  );

  assign cfg_alaw     = cfg.alaw;
  assign cfg_linear   = cfg.linear;
  assign tx_gain_code = gain_code(cfg.gain_full);
  assign chan_pd      = cfg.pd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chan_dx_en[c] = ~dev_rst & ~cfg.pd[c];
  end
endmodule

// File: tb/tb_codec_mode_ctrl.sv
module tb_codec_mode_ctrl;
  logic       clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       mode_m0 = 1'b0, mode_m1 = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic       fsync = 1'b0;
  logic [3:0] strap_pd = '0;
  logic       strap_alaw = 1'b0, strap_gain = 1'b0;
  logic       dev_rst, proc_mode, cfg_alaw, cfg_linear;
  logic [7:0] tx_gain_code;
  logic [3:0] chan_pd, chan_dx_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  codec_mode_ctrl dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .mode_m0(mode_m0), .mode_m1(mode_m1),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .fsync(fsync),
    .strap_pd(strap_pd), .strap_alaw(strap_alaw), .strap_gain(strap_gain),
    .dev_rst(dev_rst), .proc_mode(proc_mode), .cfg_alaw(cfg_alaw),
    .cfg_linear(cfg_linear), .tx_gain_code(tx_gain_code), .chan_pd(chan_pd),
    .chan_dx_en(chan_dx_en)
  );

  // bench view of the requirements
  function automatic logic [7:0] exp_gain(input logic full);
    return full ? 8'hFF : 8'h8F;
  endfunction

  function automatic logic [3:0] exp_en(input logic rst, input logic [3:0] pd);
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = !rst && !pd[i];
    return e;
  endfunction

  // cycle model: a = first stage, b = second stage of the pin synchronizer
  logic a0, a1, b0, b1, m_mode, m_prd, m_res;
  logic [6:0] m_cfg; // {linear, alaw, gain, pd[3:0]}

  function automatic logic m_dev_rst();
    return (!b0 && !b1) || m_res;
  endfunction
  function automatic logic m_proc();
    return (b0 != b1) ? b1 : m_mode;
  endfunction

  always @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      a0 = 0; a1 = 0; b0 = 0; b1 = 0; m_mode = 1; m_prd = 1; m_res = 0; m_cfg = '0;
    end else begin
      logic pr, dr, cm, rel, nres;
      pr   = !b0 && !b1;
      dr   = pr || m_res;
      cm   = (b0 != b1) ? b1 : m_mode;
      rel  = m_prd && !pr;
      nres = cm && !dr && cfg_wr_en && cfg_wr_data[7];
      if (dr) m_cfg = '0;
      else if (cm) begin
        if (cfg_wr_en && !cfg_wr_data[7]) m_cfg = cfg_wr_data[6:0];
      end else if (rel || fsync) m_cfg = {1'b0, strap_alaw, strap_gain, strap_pd};
      m_res = nres; m_mode = cm; m_prd = pr;
      b0 = a0; b1 = a1; a0 = mode_m0; a1 = mode_m1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every output with the cycle model
  task automatic model_cmp();
    logic dr;
    dr = m_dev_rst();
    chk("R1", "dev_rst", dev_rst, dr);
    chk("R2", "proc_mode", proc_mode, m_proc());
    chk(m_proc() ? "R5" : "R7", "cfg", {cfg_linear, cfg_alaw, tx_gain_code == 8'hFF, chan_pd},
        m_cfg);
    chk("R9", "tx_gain_code", tx_gain_code, exp_gain(m_cfg[4]));
    chk("R8", "chan_dx_en", chan_dx_en, exp_en(dr, m_cfg[3:0]));
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      if (sys_rst_n) model_cmp();
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr_en = 1; cfg_wr_data = d;
    tick(1);
    cfg_wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R10: power-on reset state
    chk("R10", "dev_rst", dev_rst, 1);
    chk("R10", "proc_mode", proc_mode, 1);
    chk("R10", "chan_dx_en", chan_dx_en, 0);
    chk("R10", "chan_pd", chan_pd, 0);
    sys_rst_n = 1;
    tick(1);
    // R3: pins to processor mode, two edges to take effect
    mode_m0 = 0; mode_m1 = 1;
    tick(1);
    chk("R3", "dev_rst after one edge", dev_rst, 1);
    tick(1);
    chk("R3", "dev_rst after two edges", dev_rst, 0);
    chk("R2", "proc_mode", proc_mode, 1);
    tick(1);
    // R5: store a word
    wr(8'h6A);
    chk("R5", "linear", cfg_linear, 1);
    chk("R5", "alaw", cfg_alaw, 1);
    chk("R5", "chan_pd", chan_pd, 4'hA);
    chk("R9", "gain", tx_gain_code, 8'h8F);
    chk("R8", "dx_en", chan_dx_en, 4'h5);
    wr(8'h1F);
    chk("R9", "gain full", tx_gain_code, 8'hFF);
    // R4: register reset bit
    wr(8'hC0);
    chk("R4", "dev_rst pulse", dev_rst, 1);
    chk("R4", "cfg untouched by reset write", chan_pd, 4'hF);
    tick(1);
    chk("R4", "dev_rst released", dev_rst, 0);
    chk("R4", "cfg cleared", chan_pd, 0);
    chk("R4", "gain cleared", tx_gain_code, 8'h8F);
    wr(8'h03);
    // R1: pin reset in processor mode, write during reset ignored
    mode_m1 = 0;
    tick(2);
    chk("R1", "dev_rst pin", dev_rst, 1);
    chk("R2", "mode kept in reset", proc_mode, 1);
    chk("R8", "dx_en in reset", chan_dx_en, 0);
    wr(8'h55);
    chk("R5", "write in reset ignored", chan_pd, 0);
    // R6: release into strap mode
    strap_pd = 4'h3; strap_alaw = 1; strap_gain = 1;
    mode_m0 = 1;
    tick(2);
    chk("R2", "strap mode", proc_mode, 0);
    chk("R6", "before load", chan_pd, 0);
    tick(1);
    chk("R6", "pd loaded", chan_pd, 4'h3);
    chk("R6", "alaw loaded", cfg_alaw, 1);
    chk("R6", "linear forced 0", cfg_linear, 0);
    chk("R6", "gain loaded", tx_gain_code, 8'hFF);
    // R5: write in strap mode ignored
    wr(8'h70);
    chk("R5", "strap write ignored", chan_pd, 4'h3);
    chk("R5", "strap write linear", cfg_linear, 0);
    // R7: straps change, no fsync -> hold; fsync -> reload
    strap_pd = 4'hC; strap_alaw = 0;
    tick(2);
    chk("R7", "hold without fsync", chan_pd, 4'h3);
    fsync = 1;
    tick(1);
    fsync = 0;
    chk("R7", "reload on fsync", chan_pd, 4'hC);
    chk("R7", "alaw reload", cfg_alaw, 0);
    chk("R8", "dx_en", chan_dx_en, 4'h3);
    // R7: fsync ignored in processor mode
    mode_m1 = 1; mode_m0 = 0;
    tick(3);
    strap_pd = 4'h0;
    fsync = 1;
    tick(1);
    fsync = 0;
    chk("R7", "fsync ignored in processor mode", chan_pd, 4'hC);
    // random traffic against the cycle model
    for (int k = 0; k < 4000; k++) begin
      cfg_wr_en   = ($urandom % 4) == 0;
      cfg_wr_data = $urandom;
      if (cfg_wr_data[7] && ($urandom % 4) != 0) cfg_wr_data[7] = 0;
      fsync       = ($urandom % 8) == 0;
      strap_pd    = $urandom;
      strap_alaw  = $urandom;
      strap_gain  = $urandom;
      if (($urandom % 48) == 0) begin
        case ($urandom % 4)
          0: begin mode_m0 = 0; mode_m1 = 1; end
          1: begin mode_m0 = 1; mode_m1 = 0; end
          2: begin mode_m0 = 0; mode_m1 = 0; end
          default: begin mode_m0 = 1; mode_m1 = 1; end
        endcase
      end
      tick(1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule